// File: doc/BRIEF.md
# Six-Channel PWM Output Steering Stage

This block sits between a PWM waveform generator and the output pins. It takes six raw generator signals, grouped as three even/odd channel pairs, and turns them into the six final pin levels. Three steps are applied in a fixed order. First, a pairing step can make each odd channel copy its even partner in phase. Second, a per-channel software mask can replace a channel with a programmed level. Third, a per-channel polarity control can invert the result.

A fault-handling override sits above all three steps. When it is active, it drives a 6-bit level straight onto the pins. The final levels are registered on the system clock, so every input change appears at the pins one cycle later. The generator, the dead-time logic and fault detection sit upstream and are not part of this block.

Top module: `pwm_out_steer`

## Requirements
- R1: After a clock edge with `rst_n` low, `pin_out` is 000000, whatever the other inputs are.
- R2: With `pair_mode` = 2'b00 (independent), no mask bits set, no polarity bits set and no override, `pin_out[i]` equals `raw_pwm[i]` for every channel.
- R3: With `pair_mode` = 2'b10 (synchronous), each odd channel 2k+1 takes the raw signal of its even partner 2k. Even channels keep their own raw signal.
- R4: `pair_mode` values 2'b01 (complementary, formed upstream) and 2'b11 (reserved) both behave exactly like independent mode.
- R5: When `mask_en[i]` is 1, channel i uses `mask_lvl[i]` in place of its signal after pairing. Other channels are unaffected.
- R6: When `pol_inv[i]` is 1, the level of channel i is inverted after the mask step. An inverted masked channel therefore drives the opposite of `mask_lvl[i]`.
- R7: When `ovr_act` is 1, `pin_out` equals `ovr_lvl` bit for bit. Pairing, mask and polarity are bypassed.
- R8: The output is registered. A change at any input becomes visible on `pin_out` after exactly one rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_pwm | input | 6 | Raw generator signals, bit i = channel i |
| pair_mode | input | 2 | 00 independent, 01 complementary, 10 synchronous, 11 reserved |
| mask_en | input | 6 | Per-channel mask enable |
| mask_lvl | input | 6 | Per-channel forced level used while masked |
| pol_inv | input | 6 | Per-channel output inversion |
| ovr_act | input | 1 | Override active, highest priority |
| ovr_lvl | input | 6 | Pin levels driven while override is active |
| pin_out | output | 6 | Registered final pin levels |

## Verification
Several functions can land on the same channel in the same cycle, and two collisions matter most.

- **Mask with inversion:** a mask and an inversion can act on one channel at once. The vectors set both bits together, and the result is judged against the inverse of the programmed mask level.
- **Override over everything:** the fault override can arrive while masks, inversions and synchronous pairing are all active. It is provoked with every mask and polarity bit set, and judged by requiring the raw override level at the pins.

Synchronous pairing is also combined with a mask on an odd channel. This confirms that the mask wins over the mirrored even signal.

// File: rtl/pwm_steer_pkg.sv
// Package: shared types for the PWM output steering stage.
// Assumes: the pair mode field is 2 bits wide.
package pwm_steer_pkg;

    typedef enum logic [1:0] {
        PM_INDEP = 2'b00,
        PM_COMPL = 2'b01,
        PM_SYNC  = 2'b10,
        PM_RSVD  = 2'b11
    } pair_mode_e;

endpackage

// File: rtl/pwm_pair_mux.sv
// Module: pwm_pair_mux
// Selects, for each even/odd channel pair, whether the odd channel keeps
// its own raw signal or mirrors its even partner (synchronous mode).
// Assumes: complementary waveforms are formed upstream, so that mode and
// the reserved code pass signals through unchanged.
module pwm_pair_mux
    import pwm_steer_pkg::*;
#(
    parameter int NUM_PAIRS = 3,
    localparam int NUM_CH = 2 * NUM_PAIRS
) (
    input  logic [NUM_CH-1:0] raw_i,
    input  pair_mode_e        mode_i,
    output logic [NUM_CH-1:0] paired_o
);

    logic mirror;

    // Purpose: decide once whether odd channels follow their partner.
    always_comb begin
        mirror = (mode_i == PM_SYNC);
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        // Purpose: even channel passes, odd channel picks its source.
        always_comb begin
            paired_o[2*p]   = raw_i[2*p];
            paired_o[2*p+1] = mirror ? raw_i[2*p] : raw_i[2*p+1];
        end
    end

endmodule

// File: rtl/pwm_chan_shape.sv
// Module: pwm_chan_shape
// Per-channel mask then polarity: a masked channel takes its programmed
// level, and the result is inverted when the polarity bit is set.
// Assumes: mask and polarity controls are stable software registers.
module pwm_chan_shape #(
    parameter int NUM_CH = 6
) (
    input  logic [NUM_CH-1:0] sig_i,
    input  logic [NUM_CH-1:0] mask_en_i,
    input  logic [NUM_CH-1:0] mask_lvl_i,
    input  logic [NUM_CH-1:0] pol_inv_i,
    output logic [NUM_CH-1:0] shaped_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic masked;

        // Purpose: mask step replaces the generator level.
        always_comb begin
            masked = mask_en_i[c] ? mask_lvl_i[c] : sig_i[c];
        end

        // Purpose: polarity step, applied after masking.
        always_comb begin
            shaped_o[c] = masked ^ pol_inv_i[c];
        end
    end

endmodule

// File: rtl/pwm_pin_reg.sv
// Module: pwm_pin_reg
// Final override selection and the pin register.
// Assumes: the override level is already the wanted pin level, so no
// polarity is applied to it.
module pwm_pin_reg #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] shaped_i,
    input  logic              ovr_act_i,
    input  logic [NUM_CH-1:0] ovr_lvl_i,
    output logic [NUM_CH-1:0] pin_o
);

    logic [NUM_CH-1:0] next_pin;

    // Purpose: override has priority over the shaped path.
    always_comb begin
        next_pin = ovr_act_i ? ovr_lvl_i : shaped_i;
    end

    // Purpose: register pin levels, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_o <= '0;
        end else begin
            pin_o <= next_pin;
        end
    end

endmodule

// File: rtl/pwm_out_steer.sv
// Module: pwm_out_steer (top)
// Six-channel PWM output steering: pairing, mask, polarity, override,
// then one register stage to the pins.
// Assumes: all controls come from registers in the system clock domain.
module pwm_out_steer
    import pwm_steer_pkg::*;
#(
    parameter int NUM_PAIRS = 3,
    localparam int NUM_CH = 2 * NUM_PAIRS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] raw_pwm,
    input  logic [1:0]        pair_mode,
    input  logic [NUM_CH-1:0] mask_en,
    input  logic [NUM_CH-1:0] mask_lvl,
    input  logic [NUM_CH-1:0] pol_inv,
    input  logic              ovr_act,
    input  logic [NUM_CH-1:0] ovr_lvl,
    output logic [NUM_CH-1:0] pin_out
);

    pair_mode_e        mode_q;
    logic [NUM_CH-1:0] paired;
    logic [NUM_CH-1:0] shaped;

    // Purpose: view the raw mode bits as the enumerated type.
    always_comb begin
        mode_q = pair_mode_e'(pair_mode);
    end

    pwm_pair_mux #(.NUM_PAIRS(NUM_PAIRS)) u_pair (
        .raw_i    (raw_pwm),
        .mode_i   (mode_q),
        .paired_o (paired)
    );

    pwm_chan_shape #(.NUM_CH(NUM_CH)) u_shape (
        .sig_i      (paired),
        .mask_en_i  (mask_en),
        .mask_lvl_i (mask_lvl),
        .pol_inv_i  (pol_inv),
        .shaped_o   (shaped)
    );

    pwm_pin_reg #(.NUM_CH(NUM_CH)) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .shaped_i  (shaped),
        .ovr_act_i (ovr_act),
        .ovr_lvl_i (ovr_lvl),
        .pin_o     (pin_out)
    );

    // R1: reset clears the pins on the next edge
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> pin_out == '0);

    // R7: override wins over every other path
    a_r7_override: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_act |=> pin_out == $past(ovr_lvl));

    // R2: plain independent path is a one-cycle copy
    a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_mode == 2'b00 && !ovr_act && mask_en == '0 && pol_inv == '0)
        |=> pin_out == $past(raw_pwm));

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair_chk
        // R3: in synchronous mode the odd pin mirrors its even partner
        a_r3_sync_mirror: assert property (@(posedge clk) disable iff (!rst_n)
            (pair_mode == 2'b10 && !ovr_act && mask_en == '0 && pol_inv == '0)
            |=> pin_out[2*p+1] == pin_out[2*p]);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
        // R5: a masked, non-inverted channel shows the mask level
        a_r5_mask_level: assert property (@(posedge clk) disable iff (!rst_n)
            (!ovr_act && mask_en[c] && !pol_inv[c])
            |=> pin_out[c] == $past(mask_lvl[c]));
        // R6: a masked, inverted channel shows the opposite level
        a_r6_mask_inverted: assert property (@(posedge clk) disable iff (!rst_n)
            (!ovr_act && mask_en[c] && pol_inv[c])
            |=> pin_out[c] != $past(mask_lvl[c]));
    end

endmodule

// File: tb/pwm_out_steer_test.sv
module pwm_out_steer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] raw_pwm = '0;
    logic [1:0] pair_mode = '0;
    logic [5:0] mask_en = '0;
    logic [5:0] mask_lvl = '0;
    logic [5:0] pol_inv = '0;
    logic       ovr_act = 1'b0;
    logic [5:0] ovr_lvl = '0;
    logic [5:0] pin_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pwm_out_steer uut (
        .clk(clk), .rst_n(rst_n), .raw_pwm(raw_pwm), .pair_mode(pair_mode),
        .mask_en(mask_en), .mask_lvl(mask_lvl), .pol_inv(pol_inv),
        .ovr_act(ovr_act), .ovr_lvl(ovr_lvl), .pin_out(pin_out)
    );

    typedef struct packed {
        logic [5:0] raw;
        logic [1:0] mode;
        logic [5:0] men;
        logic [5:0] mlv;
        logic [5:0] pol;
        logic       ovr;
        logic [5:0] olv;
        logic [5:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        // raw       mode   men        mlv        pol        ovr   olv        exp        req
        '{6'b101101, 2'b00, 6'b000000, 6'b000000, 6'b000000, 1'b0, 6'b000000, 6'b101101, 4'd2}, // R2
        '{6'b010010, 2'b00, 6'b000000, 6'b000000, 6'b000000, 1'b0, 6'b000000, 6'b010010, 4'd2}, // R2
        '{6'b000101, 2'b10, 6'b000000, 6'b000000, 6'b000000, 1'b0, 6'b000000, 6'b001111, 4'd3}, // R3
        '{6'b111010, 2'b10, 6'b000000, 6'b000000, 6'b000000, 1'b0, 6'b000000, 6'b110000, 4'd3}, // R3
        '{6'b100110, 2'b01, 6'b000000, 6'b000000, 6'b000000, 1'b0, 6'b000000, 6'b100110, 4'd4}, // R4
        '{6'b011001, 2'b11, 6'b000000, 6'b000000, 6'b000000, 1'b0, 6'b000000, 6'b011001, 4'd4}, // R4
        '{6'b000000, 2'b00, 6'b000011, 6'b000010, 6'b000000, 1'b0, 6'b000000, 6'b000010, 4'd5}, // R5
        '{6'b111111, 2'b00, 6'b000011, 6'b000001, 6'b000000, 1'b0, 6'b000000, 6'b111101, 4'd5}, // R5
        '{6'b000001, 2'b10, 6'b000010, 6'b000000, 6'b000000, 1'b0, 6'b000000, 6'b000001, 4'd5}, // R5 sync+mask
        '{6'b110000, 2'b00, 6'b000000, 6'b000000, 6'b100001, 1'b0, 6'b000000, 6'b010001, 4'd6}, // R6
        '{6'b000000, 2'b00, 6'b000001, 6'b000001, 6'b000001, 1'b0, 6'b000000, 6'b000000, 4'd6}, // R6 mask+inv
        '{6'b000000, 2'b00, 6'b111111, 6'b101010, 6'b111111, 1'b0, 6'b000000, 6'b010101, 4'd6}, // R6 mask+inv
        '{6'b111111, 2'b00, 6'b111111, 6'b000000, 6'b111111, 1'b1, 6'b100101, 6'b100101, 4'd7}, // R7
        '{6'b000001, 2'b10, 6'b000000, 6'b000000, 6'b000000, 1'b1, 6'b011010, 6'b011010, 4'd7}, // R7
        '{6'b101010, 2'b10, 6'b010101, 6'b111111, 6'b110011, 1'b1, 6'b000000, 6'b000000, 4'd7}  // R7
    };

    task automatic check(input logic [5:0] act, input logic [5:0] exp,
                         input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        raw_pwm = v.raw; pair_mode = v.mode; mask_en = v.men;
        mask_lvl = v.mlv; pol_inv = v.pol; ovr_act = v.ovr; ovr_lvl = v.olv;
    endtask

    initial begin
        // R1: reset with busy inputs
        raw_pwm = 6'b111111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pin_out, 6'b000000, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(pin_out, 6'b111111, "R2 after reset");

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(TBL[i]);
            @(negedge clk);
            check(pin_out, TBL[i].exp, $sformatf("R%0d vector %0d", TBL[i].req, i));
        end

        // R8: output holds until the next rising edge
        @(negedge clk);
        apply(TBL[0]);
        @(negedge clk);
        raw_pwm = 6'b010010;
        #1;
        check(pin_out, 6'b101101, "R8 no change before edge");
        @(negedge clk);
        check(pin_out, 6'b010010, "R8 change after one edge");

        // R1: mid-run reset clears pins
        raw_pwm = 6'b111111;
        rst_n = 1'b0;
        @(negedge clk);
        check(pin_out, 6'b000000, "R1 mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(pin_out, 6'b111111, "R8 resume after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule